// File: doc/BRIEF.md
# SPI Interrupt Source Aggregator

This block gathers every interrupt cause of one serial peripheral port into a single latched request line. In core mode the processor moves each word itself. A 2-bit initiation-mode field then decides whether the request follows the receive buffer filling or the transmit buffer emptying. In DMA mode the core-mode buffer causes are masked off. The request instead comes from DMA completion, from the end of a chained sequence of DMA transfers, or from a DMA error, either a multi-master conflict or an underflow/overflow. DMA causes are only admitted while the DMA interrupt enable is set.

Completion has two meanings, chosen by an end-of-transfer select bit. With the bit clear, completion is the clock edge at which the DMA word count becomes zero. With the bit set, the count reaching zero only arms a small state machine with two states, EOT_IDLE and EOT_DRAIN. Transitions: EOT_IDLE goes to EOT_DRAIN when the count rises to zero while DMA causes are admitted. EOT_DRAIN returns to EOT_IDLE and reports completion once the shifter is idle and the transmit buffer is empty. EOT_DRAIN also returns to EOT_IDLE, silently, when DMA causes stop being admitted.

The latch is a second state machine with two states, LAT_QUIET and LAT_PEND. Transitions: LAT_QUIET goes to LAT_PEND on any new cause. LAT_PEND goes back to LAT_QUIET on acknowledge, unless a new cause arrives in the same cycle. A cause register keeps one bit per source and is wiped on acknowledge. The request seen by the processor is the latch gated by a mask bit.

Top module: `spi_irq_agg`

## Requirements
- R1: After reset (asynchronous, active low), and again whenever reset is applied, irq_pend, irq_req and cause are all 0.
- R2: With dma_en=0 and tim_mode=00, a rising rx_full sets irq_pend and cause bit 0 at the clock edge where rx_full is first sampled high. The request is therefore visible one cycle after the flag rises, and not before that edge.
- R3: With dma_en=0 and tim_mode not 00, a rising tx_empty sets cause bit 1 and rx_full is ignored. With tim_mode=00, tx_empty is ignored. A level held high causes no further event.
- R4: With dma_en=1, dma_irq_en=1 and eot_sel=0, a rising dma_cnt_zero sets cause bit 2 at that edge.
- R5: With eot_sel=1, a rising dma_cnt_zero does not set cause bit 2 at that edge. Cause bit 2 is set at the first later edge where shift_idle and tx_empty are both high. The pending completion is dropped if DMA causes are disabled meanwhile.
- R6: With DMA causes admitted, chain_done sets cause bit 3 only while chain_en=1.
- R7: With DMA causes admitted, err_mm sets cause bit 4 and err_uo sets cause bit 5 in the cycle they are high.
- R8: DMA causes (cause bits 2 to 5) are ignored unless dma_en=1 and dma_irq_en=1.
- R9: Core buffer causes (cause bits 0 and 1) are ignored while dma_en=1.
- R10: irq_req is high exactly when irq_pend is high and irq_mask=1.
- R11: irq_ack with no new cause clears irq_pend and cause at that edge.
- R12: irq_ack in the same cycle as a new cause leaves irq_pend high, with cause holding only the new bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_en | input | 1 | 1 selects DMA mode, 0 selects core mode |
| dma_irq_en | input | 1 | Admits DMA-sourced causes |
| chain_en | input | 1 | DMA chaining enabled |
| eot_sel | input | 1 | 0: completion at count zero, 1: completion at shift-out |
| tim_mode | input | 2 | Core-mode source: 00 receive full, other values transmit empty |
| rx_full | input | 1 | Receive buffer full flag |
| tx_empty | input | 1 | Transmit buffer empty flag |
| dma_cnt_zero | input | 1 | DMA word count is zero |
| chain_done | input | 1 | Chained DMA sequence finished strobe |
| err_mm | input | 1 | Multi-master error strobe |
| err_uo | input | 1 | Underflow/overflow error strobe |
| shift_idle | input | 1 | Shift register has nothing left to send |
| irq_mask | input | 1 | 1 lets the latched request through |
| irq_ack | input | 1 | Acknowledge (return from interrupt) strobe |
| irq_req | output | 1 | Masked request to the processor |
| irq_pend | output | 1 | Latched request before the mask |
| cause | output | 6 | Cause bits: 0 rx-full, 1 tx-empty, 2 DMA done, 3 chain done, 4 multi-master, 5 under/overflow |

## Verification
The main vector walk first exercises core mode with a rising receive flag, a rising transmit flag under each mode value, and flags held high. This separates edge detection from level detection and shows whether the mode field routes the correct source. The DMA rows send count-zero, chain and error strobes with the interrupt enable and the chain enable each toggled. These rows tell a correctly gated cause from a leaking one. Completion under both end-of-transfer settings is shown to fire at the count edge in one case and only at shifter drain in the other. Directed cases cover the exact cycle of the receive request, an armed drain cancelled by leaving DMA mode, acknowledge colliding with a new cause, and reset while a request is pending.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    localparam int NUM_CAUSE = 6;
    localparam int TIM_W     = 2;
    localparam int N_EDGE    = 3;

    // cause bit positions
    localparam int CI_RX    = 0;
    localparam int CI_TX    = 1;
    localparam int CI_DONE  = 2;
    localparam int CI_CHAIN = 3;
    localparam int CI_MM    = 4;
    localparam int CI_UO    = 5;

    // edge detector lane positions
    localparam int EI_RX = 0;
    localparam int EI_TX = 1;
    localparam int EI_CZ = 2;

    localparam logic [TIM_W-1:0] TIM_RXFULL = '0;

    typedef enum logic {EOT_IDLE, EOT_DRAIN} eot_state_e;
    typedef enum logic {LAT_QUIET, LAT_PEND} lat_state_e;

endpackage

// File: rtl/spi_irq_edge.sv
module spi_irq_edge #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] rise
);

    for (genvar g = 0; g < W; g++) begin : g_lane
        logic prev_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= din[g];
        end
        assign rise[g] = din[g] & ~prev_q;
    end

endmodule

// File: rtl/spi_irq_eot.sv
module spi_irq_eot
    import spi_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic eot_sel,
    input  logic cnt_rise,
    input  logic shift_idle,
    input  logic tx_empty,
    output logic done
);

    eot_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EOT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        done    = 1'b0;
        unique case (state_q)
            EOT_IDLE: begin
                if (active && cnt_rise) begin
                    if (eot_sel) state_d = EOT_DRAIN;
                    else         done    = 1'b1;
                end
            end
            EOT_DRAIN: begin
                if (!active) begin
                    state_d = EOT_IDLE;
                end else if (shift_idle && tx_empty) begin
                    done    = 1'b1;
                    state_d = EOT_IDLE;
                end
            end
        endcase
    end

endmodule

// File: rtl/spi_irq_latch.sv
module spi_irq_latch
    import spi_irq_pkg::*;
#(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic         ack,
    output logic         pend,
    output logic [N-1:0] cause
);

    lat_state_e   state_q, state_d;
    logic [N-1:0] cause_q, cause_d;
    logic         any_set;

    assign any_set = |set_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LAT_QUIET;
            cause_q <= '0;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cause_d = cause_q;
        unique case (state_q)
            LAT_QUIET: begin
                cause_d = set_vec;
                if (any_set) state_d = LAT_PEND;
            end
            LAT_PEND: begin
                if (ack) begin
                    cause_d = set_vec;
                    if (!any_set) state_d = LAT_QUIET;
                end else begin
                    cause_d = cause_q | set_vec;
                end
            end
        endcase
    end

    always_comb begin
        pend  = (state_q == LAT_PEND);
        cause = cause_q;
    end

endmodule

// File: rtl/spi_irq_agg.sv
module spi_irq_agg
    import spi_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dma_en,
    input  logic             dma_irq_en,
    input  logic             chain_en,
    input  logic             eot_sel,
    input  logic [TIM_W-1:0] tim_mode,
    input  logic             rx_full,
    input  logic             tx_empty,
    input  logic             dma_cnt_zero,
    input  logic             chain_done,
    input  logic             err_mm,
    input  logic             err_uo,
    input  logic             shift_idle,
    input  logic             irq_mask,
    input  logic             irq_ack,
    output logic             irq_req,
    output logic             irq_pend,
    output logic [NUM_CAUSE-1:0] cause
);

    logic [N_EDGE-1:0]    edge_in, edge_rise;
    logic [NUM_CAUSE-1:0] new_cause;
    logic                 core_on, dma_on, eot_done;

    assign edge_in[EI_RX] = rx_full;
    assign edge_in[EI_TX] = tx_empty;
    assign edge_in[EI_CZ] = dma_cnt_zero;

    spi_irq_edge #(.W(N_EDGE)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (edge_in),
        .rise (edge_rise)
    );

    assign core_on = ~dma_en;
    assign dma_on  = dma_en & dma_irq_en;

    spi_irq_eot u_eot (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (dma_on),
        .eot_sel   (eot_sel),
        .cnt_rise  (edge_rise[EI_CZ]),
        .shift_idle(shift_idle),
        .tx_empty  (tx_empty),
        .done      (eot_done)
    );

    always_comb begin
        new_cause           = '0;
        new_cause[CI_RX]    = core_on & (tim_mode == TIM_RXFULL) & edge_rise[EI_RX];
        new_cause[CI_TX]    = core_on & (tim_mode != TIM_RXFULL) & edge_rise[EI_TX];
        new_cause[CI_DONE]  = eot_done;
        new_cause[CI_CHAIN] = dma_on & chain_en & chain_done;
        new_cause[CI_MM]    = dma_on & err_mm;
        new_cause[CI_UO]    = dma_on & err_uo;
    end

    spi_irq_latch #(.N(NUM_CAUSE)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_vec(new_cause),
        .ack    (irq_ack),
        .pend   (irq_pend),
        .cause  (cause)
    );

    assign irq_req = irq_pend & irq_mask;

endmodule

// File: rtl/spi_irq_agg_chk.sv
module spi_irq_agg_chk
    import spi_irq_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 dma_en,
    input logic                 dma_irq_en,
    input logic                 eot_sel,
    input logic [TIM_W-1:0]     tim_mode,
    input logic                 rx_full,
    input logic                 dma_cnt_zero,
    input logic                 irq_mask,
    input logic                 irq_ack,
    input logic                 irq_req,
    input logic                 irq_pend,
    input logic [NUM_CAUSE-1:0] cause,
    input logic [NUM_CAUSE-1:0] new_cause
);

    p_rx_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_en && tim_mode == TIM_RXFULL && $rose(rx_full))
        |=> (irq_pend && cause[CI_RX]));

    p_count_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en && dma_irq_en && !eot_sel && $rose(dma_cnt_zero))
        |=> (irq_pend && cause[CI_DONE]));

    p_dma_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((!dma_en || !dma_irq_en) && !irq_ack)
        |=> (cause[NUM_CAUSE-1:CI_DONE] == $past(cause[NUM_CAUSE-1:CI_DONE])));

    p_core_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en && !irq_ack)
        |=> (cause[CI_TX:CI_RX] == $past(cause[CI_TX:CI_RX])));

    p_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_mask |-> !irq_req);

    p_ack_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && new_cause == '0) |=> (!irq_pend && cause == '0));

    p_ack_collide_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && new_cause != '0) |=> (irq_pend && cause == $past(new_cause)));

endmodule

bind spi_irq_agg spi_irq_agg_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dma_en      (dma_en),
    .dma_irq_en  (dma_irq_en),
    .eot_sel     (eot_sel),
    .tim_mode    (tim_mode),
    .rx_full     (rx_full),
    .dma_cnt_zero(dma_cnt_zero),
    .irq_mask    (irq_mask),
    .irq_ack     (irq_ack),
    .irq_req     (irq_req),
    .irq_pend    (irq_pend),
    .cause       (cause),
    .new_cause   (new_cause)
);

// File: tb/spi_irq_agg_bench.sv
module spi_irq_agg_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N_ROWS     = 21;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dma_en = 0, dma_irq_en = 0, chain_en = 0, eot_sel = 0;
    logic [1:0] tim_mode = 2'b00;
    logic       rx_full = 0, tx_empty = 0, dma_cnt_zero = 0, chain_done = 0;
    logic       err_mm = 0, err_uo = 0, shift_idle = 0, irq_mask = 0, irq_ack = 0;
    logic       irq_req, irq_pend;
    logic [5:0] cause;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_irq_agg u_spi_irq_agg (
        .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .dma_irq_en(dma_irq_en),
        .chain_en(chain_en), .eot_sel(eot_sel), .tim_mode(tim_mode),
        .rx_full(rx_full), .tx_empty(tx_empty), .dma_cnt_zero(dma_cnt_zero),
        .chain_done(chain_done), .err_mm(err_mm), .err_uo(err_uo),
        .shift_idle(shift_idle), .irq_mask(irq_mask), .irq_ack(irq_ack),
        .irq_req(irq_req), .irq_pend(irq_pend), .cause(cause)
    );

    // row: dma ien eot | tim | rx tx cz chen cd mm uo si mk ak | pend | cause | req | req-tag
    localparam logic [26:0] TABLE [N_ROWS] = '{
        27'b000_00_1000000010_1_000001_1_0010, // R2 rx rise
        27'b000_00_1000000011_0_000000_0_1011, // R11 ack, rx held
        27'b000_00_0100000010_0_000000_0_0011, // R3 tx rise under rx mode
        27'b000_01_0100000010_0_000000_0_0011, // R3 tx held, no edge
        27'b000_01_0000000010_0_000000_0_0011, // R3 tx low
        27'b000_01_0100000000_1_000010_0_1010, // R10 tx rise, mask 0
        27'b000_01_0100000010_1_000010_1_1010, // R10 mask 1
        27'b000_00_1100000011_1_000001_1_1100, // R12 ack with rx rise
        27'b000_00_1100000011_0_000000_0_1011, // R11 ack clears
        27'b110_00_0010000010_1_000100_1_0100, // R4 count zero
        27'b110_00_1010000011_0_000000_0_1001, // R9 rx rise ignored in DMA
        27'b100_00_0010010010_0_000000_0_1000, // R8 irq enable off
        27'b110_00_0010011010_1_110000_1_0111, // R7 both errors
        27'b110_00_0010100011_0_000000_0_0110, // R6 chain disabled, ack
        27'b110_00_0011100010_1_001000_1_0110, // R6 chain done
        27'b110_00_0000000011_0_000000_0_1011, // R11 ack
        27'b111_00_0110000110_0_000000_0_0101, // R5 arm, no fire
        27'b111_00_0110000010_0_000000_0_0101, // R5 shifter busy
        27'b111_00_0110000110_1_000100_1_0101, // R5 drained
        27'b111_00_0100000111_0_000000_0_1011, // R11 ack
        27'b000_00_0101110010_0_000000_0_1000  // R8 DMA strobes in core mode
    };

    task automatic check(input string tag, input logic ep, input logic [5:0] ec, input logic er);
        n_tests++;
        if (irq_pend !== ep || cause !== ec || irq_req !== er) begin
            n_fail++;
            $display("FAIL %s: pend=%b cause=%b req=%b expected pend=%b cause=%b req=%b",
                     tag, irq_pend, cause, irq_req, ep, ec, er);
        end
    endtask

    task automatic clear_inputs();
        dma_en = 0; dma_irq_en = 0; chain_en = 0; eot_sel = 0; tim_mode = 2'b00;
        rx_full = 0; tx_empty = 0; dma_cnt_zero = 0; chain_done = 0;
        err_mm = 0; err_uo = 0; shift_idle = 0; irq_mask = 1; irq_ack = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state", 1'b0, 6'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < N_ROWS; i++) begin
            logic [26:0] v;
            v = TABLE[i];
            {dma_en, dma_irq_en, eot_sel} = v[26:24];
            tim_mode = v[23:22];
            {rx_full, tx_empty, dma_cnt_zero, chain_en, chain_done,
             err_mm, err_uo, shift_idle, irq_mask, irq_ack} = v[21:12];
            step();
            check($sformatf("R%0d row %0d", v[3:0], i), v[11], v[10:5], v[4]);
        end

        // R2: request not visible before the edge, visible after it
        clear_inputs();
        step();
        rx_full = 1;
        #1;
        check("R2 before edge", 1'b0, 6'b0, 1'b0);
        step();
        check("R2 after edge", 1'b1, 6'b000001, 1'b1);
        irq_ack = 1;
        step();
        irq_ack = 0;
        check("R11 directed ack", 1'b0, 6'b0, 1'b0);

        // R5: armed drain cancelled by leaving DMA mode
        clear_inputs();
        dma_en = 1; dma_irq_en = 1; eot_sel = 1;
        step();
        dma_cnt_zero = 1; tx_empty = 1;
        step();
        check("R5 armed", 1'b0, 6'b0, 1'b0);
        dma_en = 0;
        step();
        dma_en = 1; shift_idle = 1;
        step();
        check("R5 cancelled drain", 1'b0, 6'b0, 1'b0);

        // R1: reset while pending
        clear_inputs();
        step();
        rx_full = 1;
        step();
        check("R1 pre-reset pending", 1'b1, 6'b000001, 1'b1);
        rst_n = 0;
        #1;
        check("R1 reset while pending", 1'b0, 6'b0, 1'b0);
        step();
        rst_n = 1;
        step();

        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule